// File: doc/BRIEF.md
# Multichannel Cascaded Biquad Equalizer Engine

This block is an audio equalizer accelerator. It runs cascades of second-order IIR sections through one shared multiply-accumulate datapath. A mode input selects how the engine is divided. In two-channel operation, channels A and B each pass through ten sections. In four-channel operation, channels A, B, C and D each pass through five sections. Each sample set takes 20 section evaluations in either mode. At six cycles per evaluation, the whole set finishes in 120 clocks, which is well inside the 480-clock sample period.

A start pulse marks each sample period and lasts three clocks. Its first cycle captures the four 18-bit inputs, publishes the results of the previous set on the four 18-bit outputs, and starts the sequencer. The 40 coefficient words of 16 bits are loaded through a valid/acknowledge port. A word is only taken while the engine is idle, so a sample set is never filtered with a mix of old and new coefficients.

Top module: `eq_engine`

## Requirements
- R1: With `quad_mode`=0, channels A and B each run sections 0..9, and section s uses words 4s..4s+3 for both channels. With `quad_mode`=1, channels A..D each run sections 0..4. Channels A and B use words 4s..4s+3, and channels C and D use words 20+4s..23+4s.
- R2: A section computes acc = x·2^14 + k0·x[n-1] + k1·x[n-2] − k2·y[n-1] − k3·y[n-2]. Here k0..k3 are its four words in order, as signed Q2.14 values. Each section's output feeds the next section, and the last section's output is the channel result.
- R3: The section output is floor((acc + 2^13) / 2^14), saturated to the range −131072..131071.
- R4: Only the first cycle of a high level on `start` acts, and only while the engine is not computing. That cycle captures `in_a`..`in_d` and copies the previous results to `out_a`..`out_d`. Input changes during the rest of the pulse are ignored, and the outputs change at no other time.
- R5: `calc_done` is low from the cycle after a start until computation ends. It rises fewer than 480 cycles after the start and stays high until the next start.
- R6: In two-channel mode, the results published for channels C and D are zero, whatever is on `in_c` and `in_d`.
- R7: Every channel and section keeps its own x[n-1], x[n-2], y[n-1] and y[n-2]. All of this history is cleared by reset and whenever `quad_mode` changes.
- R8: A coefficient write is stored only while no computation is running. `cfg_ack` is then high for exactly one cycle, one cycle after the write is taken. A write presented during computation waits until the engine is idle.
- R9: A write to an address above 39 is never acknowledged and stores nothing.
- R10: After reset, all outputs are zero, and `calc_done` and `cfg_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_mode | input | 1 | 0: two channels x 10 sections, 1: four channels x 5 sections |
| start | input | 1 | Three-cycle sample period pulse |
| in_a | input | 18 | Channel A input sample (front left) |
| in_b | input | 18 | Channel B input sample (front right) |
| in_c | input | 18 | Channel C input sample (rear left) |
| in_d | input | 18 | Channel D input sample (rear right) |
| cfg_valid | input | 1 | Coefficient write request |
| cfg_addr | input | 6 | Coefficient word address, 0..39 |
| cfg_word | input | 16 | Coefficient value, signed Q2.14 |
| cfg_ack | output | 1 | One-cycle acknowledge of a stored word |
| out_a | output | 18 | Channel A result |
| out_b | output | 18 | Channel B result |
| out_c | output | 18 | Channel C result |
| out_d | output | 18 | Channel D result |
| calc_done | output | 1 | High once the current sample set is finished |

## Verification
Inputs are driven at full scale in both directions so that the section outputs saturate. A design that wrapped instead of clamping, or that rounded at a different point, would diverge from the reference cascade within a few samples.

The bench switches the mode twice while filter history is non-zero. A design that kept stale history, or that used the wrong coefficient bank for channels C and D, would produce wrong four-channel results. Garbage inputs during the second and third cycles of the start pulse catch a design that recaptures its inputs on every high cycle. Non-zero inputs on C and D in two-channel mode catch a design whose C and D results are not zero.

A coefficient write is held pending throughout a computation, which catches a design that mixes old and new words within one set. A write to address 45 catches a design that acknowledges out-of-range addresses.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int SMP_W      = 18;
  localparam int CF_W       = 16;
  localparam int ACC_W      = 40;
  localparam int FRAC       = 14;
  localparam int N_WORDS    = 40;
  localparam int ADDR_W     = 6;
  localparam int CYC_BUDGET = 480;

  typedef enum logic [2:0] {
    ST_LOAD = 3'd0,
    ST_B1   = 3'd1,
    ST_B2   = 3'd2,
    ST_A1   = 3'd3,
    ST_A2   = 3'd4,
    ST_OUT  = 3'd5
  } step_t;
endpackage

// File: rtl/eq_coef_store.sv
module eq_coef_store #(
  parameter int WORDS = 40,
  parameter int AW    = 6,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_open,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_data,
  output logic          ack,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [CW-1:0] mem [0:WORDS-1];
  logic          take;

  assign take = req_valid && wr_open && !ack && (req_addr < AW'(WORDS));

  always_ff @(posedge clk) begin
    if (take) mem[req_addr] <= req_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= take;
  end
endmodule

// File: rtl/eq_sequencer.sv
module eq_sequencer import eq_pkg::*; #(
  parameter int SEC_TWO   = 10,
  parameter int SEC_FOUR  = 5,
  parameter int REAR_BASE = 20,
  parameter int WPS       = 4,
  parameter int AW        = 6,
  parameter int SEC_W     = 4,
  parameter int SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              quad,
  output logic              busy,
  output logic              done,
  output step_t             step,
  output logic [1:0]        ch,
  output logic [SEC_W-1:0]  sec,
  output logic [SLOT_W-1:0] slot,
  output logic [AW-1:0]     rd_addr,
  output logic              sec_end
);
  logic       mode_run;
  logic       chan_end;
  logic       last_sec;
  logic       last_ch;
  logic [2:0] sidx;

  assign sidx = step;

  always_comb begin
    last_sec = mode_run ? (sec == SEC_W'(SEC_FOUR - 1)) : (sec == SEC_W'(SEC_TWO - 1));
    last_ch  = mode_run ? (ch == 2'd3) : (ch == 2'd1);
    sec_end  = (step == ST_OUT) && last_sec;
    chan_end = sec_end && last_ch;
    slot     = mode_run ? SLOT_W'(SLOT_W'(ch) * SLOT_W'(SEC_FOUR) + SLOT_W'(sec))
                        : SLOT_W'(SLOT_W'(ch) * SLOT_W'(SEC_TWO) + SLOT_W'(sec));
    rd_addr  = AW'((mode_run && ch[1]) ? REAR_BASE : 0)
             + AW'(AW'(WPS) * AW'(sec)) + AW'(sidx[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mode_run <= 1'b0;
      step     <= ST_LOAD;
      ch       <= '0;
      sec      <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      mode_run <= quad;
      step     <= ST_LOAD;
      ch       <= '0;
      sec      <= '0;
    end else if (busy) begin
      if (step == ST_OUT) begin
        step <= ST_LOAD;
        if (chan_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (sec_end) begin
          sec <= '0;
          ch  <= ch + 2'd1;
        end else begin
          sec <= sec + SEC_W'(1);
        end
      end else begin
        step <= step_t'(sidx + 3'd1);
      end
    end
  end
endmodule

// File: rtl/eq_mac.sv
module eq_mac import eq_pkg::*; #(
  parameter int SW = 18,
  parameter int CW = 16,
  parameter int AW = 40,
  parameter int FR = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  step_t                step,
  input  logic signed [SW-1:0] x,
  input  logic signed [SW-1:0] x1,
  input  logic signed [SW-1:0] x2,
  input  logic signed [SW-1:0] y1,
  input  logic signed [SW-1:0] y2,
  input  logic signed [CW-1:0] coef,
  output logic signed [SW-1:0] y
);
  localparam logic signed [AW-1:0] HI   = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO   = {{(AW-SW+1){1'b1}}, {(SW-1){1'b0}}};
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FR - 1);

  logic signed [AW-1:0] acc, prod, rnd, shr;
  logic signed [SW-1:0] mop;

  always_comb begin
    case (step)
      ST_B1:   mop = x1;
      ST_B2:   mop = x2;
      ST_A1:   mop = y1;
      ST_A2:   mop = y2;
      default: mop = x;
    endcase
    prod = AW'(coef) * AW'(mop);
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else begin
      case (step)
        ST_LOAD:      acc <= AW'(x) <<< FR;
        ST_B1, ST_B2: acc <= acc + prod;
        ST_A1, ST_A2: acc <= acc - prod;
        default:      acc <= acc;
      endcase
    end
  end

  always_comb begin
    rnd = acc + HALF;
    shr = rnd >>> FR;
    if (shr > HI)      y = HI[SW-1:0];
    else if (shr < LO) y = LO[SW-1:0];
    else               y = shr[SW-1:0];
  end
endmodule

// File: rtl/eq_engine.sv
module eq_engine import eq_pkg::*; #(
  parameter int SMP_W     = eq_pkg::SMP_W,
  parameter int CF_W      = eq_pkg::CF_W,
  parameter int ACC_W     = eq_pkg::ACC_W,
  parameter int FRAC      = eq_pkg::FRAC,
  parameter int N_WORDS   = eq_pkg::N_WORDS,
  parameter int ADDR_W    = eq_pkg::ADDR_W,
  parameter int SEC_TWO   = 10,
  parameter int SEC_FOUR  = 5,
  parameter int REAR_BASE = 20,
  parameter int WPS       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              quad_mode,
  input  logic              start,
  input  logic [SMP_W-1:0]  in_a,
  input  logic [SMP_W-1:0]  in_b,
  input  logic [SMP_W-1:0]  in_c,
  input  logic [SMP_W-1:0]  in_d,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CF_W-1:0]   cfg_word,
  output logic              cfg_ack,
  output logic [SMP_W-1:0]  out_a,
  output logic [SMP_W-1:0]  out_b,
  output logic [SMP_W-1:0]  out_c,
  output logic [SMP_W-1:0]  out_d,
  output logic              calc_done
);
  localparam int N_CH   = 4;
  localparam int N_SLOT = 2 * SEC_TWO;
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int SEC_W  = $clog2(SEC_TWO);

  logic start_q, mode_q, launch, busy, sec_end, hist_clr;
  step_t step;
  logic [1:0]        ch;
  logic [SEC_W-1:0]  sec;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] rd_addr;
  logic [CF_W-1:0]   cf_rd;

  logic signed [SMP_W-1:0] in_reg [0:N_CH-1];
  logic signed [SMP_W-1:0] res    [0:N_CH-1];
  logic [SMP_W-1:0]        out_r  [0:N_CH-1];
  logic signed [SMP_W-1:0] hx1 [0:N_SLOT-1];
  logic signed [SMP_W-1:0] hx2 [0:N_SLOT-1];
  logic signed [SMP_W-1:0] hy1 [0:N_SLOT-1];
  logic signed [SMP_W-1:0] hy2 [0:N_SLOT-1];
  logic signed [SMP_W-1:0] chain, sec_in, y_sec;

  assign launch   = start && !start_q && !busy;
  assign hist_clr = quad_mode != mode_q;
  assign sec_in   = (sec == '0) ? in_reg[ch] : chain;

  eq_sequencer #(
    .SEC_TWO(SEC_TWO), .SEC_FOUR(SEC_FOUR), .REAR_BASE(REAR_BASE), .WPS(WPS),
    .AW(ADDR_W), .SEC_W(SEC_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .quad(quad_mode),
    .busy(busy), .done(calc_done), .step(step), .ch(ch), .sec(sec),
    .slot(slot), .rd_addr(rd_addr), .sec_end(sec_end)
  );

  eq_coef_store #(.WORDS(N_WORDS), .AW(ADDR_W), .CW(CF_W)) u_coef (
    .clk(clk), .rst(rst), .wr_open(!busy), .req_valid(cfg_valid),
    .req_addr(cfg_addr), .req_data(cfg_word), .ack(cfg_ack),
    .rd_addr(rd_addr), .rd_data(cf_rd)
  );

  eq_mac #(.SW(SMP_W), .CW(CF_W), .AW(ACC_W), .FR(FRAC)) u_mac (
    .clk(clk), .rst(rst), .step(step), .x(sec_in),
    .x1(hx1[slot]), .x2(hx2[slot]), .y1(hy1[slot]), .y2(hy2[slot]),
    .coef($signed(cf_rd)), .y(y_sec)
  );

  always_ff @(posedge clk) begin
    if (rst || hist_clr) begin
      for (int i = 0; i < N_SLOT; i++) begin
        hx1[i] <= '0;
        hx2[i] <= '0;
        hy1[i] <= '0;
        hy2[i] <= '0;
      end
    end else if (busy && step == ST_OUT) begin
      hx1[slot] <= sec_in;
      hx2[slot] <= hx1[slot];
      hy1[slot] <= y_sec;
      hy2[slot] <= hy1[slot];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      mode_q  <= quad_mode;
      chain   <= '0;
      for (int i = 0; i < N_CH; i++) begin
        in_reg[i] <= '0;
        res[i]    <= '0;
        out_r[i]  <= '0;
      end
    end else begin
      start_q <= start;
      mode_q  <= quad_mode;
      if (launch) begin
        in_reg[0] <= $signed(in_a);
        in_reg[1] <= $signed(in_b);
        in_reg[2] <= $signed(in_c);
        in_reg[3] <= $signed(in_d);
        for (int i = 0; i < N_CH; i++) out_r[i] <= res[i];
        if (!quad_mode) begin
          res[2] <= '0;
          res[3] <= '0;
        end
      end else if (busy && step == ST_OUT) begin
        chain <= y_sec;
        if (sec_end) res[ch] <= y_sec;
      end
    end
  end

  assign out_a = out_r[0];
  assign out_b = out_r[1];
  assign out_c = out_r[2];
  assign out_d = out_r[3];
endmodule

// File: rtl/eq_engine_chk.sv
module eq_engine_chk #(
  parameter int BUDGET = 480,
  parameter int WORDS  = 40,
  parameter int AW     = 6,
  parameter int SW     = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          launch,
  input logic          calc_done,
  input logic          cfg_valid,
  input logic [AW-1:0] cfg_addr,
  input logic          cfg_ack,
  input logic [SW-1:0] out_a,
  input logic [SW-1:0] out_b,
  input logic [SW-1:0] out_c,
  input logic [SW-1:0] out_d
);
  int unsigned cyc;

  always_ff @(posedge clk) begin
    if (rst || launch) cyc <= 0;
    else if (busy)     cyc <= cyc + 1;
  end

  // R5
  budget_chk: assert property (@(posedge clk) disable iff (rst) busy |-> cyc < BUDGET);
  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst) calc_done |-> !busy);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst) launch |=> !calc_done);
  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst) cfg_ack |-> $past(cfg_valid && !busy));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) cfg_ack |=> !cfg_ack);
  // R9
  ack_range_chk: assert property (@(posedge clk) disable iff (rst) cfg_ack |-> $past(cfg_addr) < AW'(WORDS));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(launch) |-> ($stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(out_d)));
endmodule

bind eq_engine eq_engine_chk #(
  .BUDGET(eq_pkg::CYC_BUDGET), .WORDS(N_WORDS), .AW(ADDR_W), .SW(SMP_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .launch(launch), .calc_done(calc_done),
  .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_ack(cfg_ack),
  .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
);

// File: tb/eq_engine_test.sv
`timescale 1ns/1ps
module eq_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quad_mode = 1'b0, start = 1'b0, cfg_valid = 1'b0, cfg_ack, calc_done;
  logic [17:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [17:0] out_a, out_b, out_c, out_d;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_word = '0;

  always #4 clk = ~clk;

  eq_engine uut (
    .clk(clk), .rst(rst), .quad_mode(quad_mode), .start(start),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_word(cfg_word), .cfg_ack(cfg_ack),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d), .calc_done(calc_done)
  );

  int n_tests = 0, n_fail = 0;
  int cf [0:39];
  longint mx1 [0:3][0:9], mx2 [0:3][0:9], my1 [0:3][0:9], my2 [0:3][0:9];
  int pub [0:3];
  int pub_quad = 0;
  int last_quad = -1;

  // columns: quad_mode, in_a, in_b, in_c, in_d
  localparam int NV = 24;
  localparam int VEC [0:NV-1][0:4] = '{
    '{0, 60000, -30000, 0, 0}, '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0},
    '{0, 20000, 20000, 0, 0}, '{0, 20000, 20000, 0, 0}, '{0, 20000, 20000, 0, 0},
    '{0, -77001, 123456, 5, 9}, '{0, 131071, -131072, 0, 0}, '{0, -1000, 4242, 0, 0},
    '{1, 50000, -50000, 40000, -40000}, '{1, 0, 0, 0, 0}, '{1, 0, 0, 0, 0},
    '{1, -25000, 25000, 12000, -12000}, '{1, -25000, 25000, 12000, -12000},
    '{1, -25000, 25000, 12000, -12000},
    '{1, 131071, 131071, -131072, -131072}, '{1, 999, -8888, 77777, -6543}, '{1, 0, 0, 0, 0},
    '{0, 100, 200, 300, 400}, '{0, 0, 0, 0, 0}, '{0, 131071, 131071, 131071, 131071},
    '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0}
  };

  function automatic int coef_val(int k);
    return ((k * 2731 + 517) % 12000) - 6000;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 10; s++) begin
        mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
      end
  endtask

  // reference cascade per R1, R2, R3, R7
  task automatic model(int q, int a, int b, int c, int d);
    int inp [0:3];
    int nch, nsec, base;
    longint x, acc, y;
    inp[0] = a; inp[1] = b; inp[2] = c; inp[3] = d;
    nch  = q ? 4 : 2;
    nsec = q ? 5 : 10;
    for (int ch = 0; ch < 4; ch++) pub[ch] = 0;
    for (int ch = 0; ch < nch; ch++) begin
      x = inp[ch];
      for (int s = 0; s < nsec; s++) begin
        base = ((q != 0 && ch >= 2) ? 20 : 0) + 4 * s;
        acc = x * 16384 + cf[base] * mx1[ch][s] + cf[base+1] * mx2[ch][s]
            - cf[base+2] * my1[ch][s] - cf[base+3] * my2[ch][s];
        y = (acc + 8192) >>> 14;
        if (y > 131071) y = 131071;
        if (y < -131072) y = -131072;
        mx2[ch][s] = mx1[ch][s]; mx1[ch][s] = x;
        my2[ch][s] = my1[ch][s]; my1[ch][s] = y;
        x = y;
      end
      pub[ch] = int'(x);
    end
    pub_quad = q;
  endtask

  task automatic write_coef(int addr, int data, int exp_ack, string req);
    int got = 0;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = 6'(addr); cfg_word = 16'(data);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cfg_ack) begin got = 1; break; end
    end
    cfg_valid = 1'b0;
    check(req, got, exp_ack);
    if (got == 1 && addr < 40) cf[addr] = data;
  endtask

  task automatic check_outputs();
    check("R1,R2,R3,R7 out_a", int'($signed(out_a)), pub[0]);
    check("R1,R2,R3,R7 out_b", int'($signed(out_b)), pub[1]);
    check(pub_quad ? "R1,R2,R3,R7 out_c" : "R6 out_c", int'($signed(out_c)), pub[2]);
    check(pub_quad ? "R1,R2,R3,R7 out_d" : "R6 out_d", int'($signed(out_d)), pub[3]);
  endtask

  // one sample period; wr_addr >= 0 requests a write while computing (R8)
  task automatic do_sample(int q, int a, int b, int c, int d, int wr_addr, int wr_data);
    int cnt = 0;
    int early = 0;
    int got = 0;
    @(negedge clk);
    if (q != last_quad) begin
      quad_mode = q[0];
      @(negedge clk); @(negedge clk);
      if (last_quad != -1) clear_model();
      last_quad = q;
    end
    in_a = 18'(a); in_b = 18'(b); in_c = 18'(c); in_d = 18'(d);
    start = 1'b1;
    @(negedge clk);
    check_outputs();
    check("R5 done cleared at start", int'(calc_done), 0);
    model(q, a, b, c, d);
    in_a = 18'h15555; in_b = 18'h2aaaa; in_c = 18'h0f0f0; in_d = 18'h33333;
    @(negedge clk); @(negedge clk);
    start = 1'b0;
    cnt = 3;
    if (wr_addr >= 0) begin
      cfg_valid = 1'b1; cfg_addr = 6'(wr_addr); cfg_word = 16'(wr_data);
    end
    while (!calc_done && cnt < 600) begin
      @(negedge clk);
      cnt++;
      if (!calc_done && cfg_ack) early = 1;
    end
    check("R5 done before 480 cycles", int'(cnt < 480), 1);
    if (wr_addr >= 0) begin
      check("R8 no ack while computing", early, 0);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (cfg_ack) begin got = 1; break; end
      end
      cfg_valid = 1'b0;
      check("R8 pending write acked when idle", got, 1);
      if (got == 1) cf[wr_addr] = wr_data;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 40; i++) cf[i] = 0;
    for (int i = 0; i < 4; i++) pub[i] = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 out_a", int'(out_a), 0);
    check("R10 out_d", int'(out_d), 0);
    check("R10 calc_done", int'(calc_done), 0);
    check("R10 cfg_ack", int'(cfg_ack), 0);

    for (int k = 0; k < 40; k++) write_coef(k, coef_val(k), 1, "R8 idle write");

    for (int v = 0; v < NV; v++)
      do_sample(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], -1, 0);

    // R8: a write held during computation is only taken afterwards
    do_sample(1, 30000, -30000, 15000, 70000, 22, 9000);
    do_sample(1, 30000, -30000, 15000, 70000, -1, 0);
    // R9: out-of-range address is never acknowledged and changes nothing
    write_coef(45, 1234, 0, "R9 address above 39");
    do_sample(1, -4000, 4000, 99999, -99999, -1, 0);
    do_sample(0, 50000, -50000, 1, 1, -1, 0);
    do_sample(0, 0, 0, 0, 0, -1, 0);

    // R10: reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 out_b after reset", int'(out_b), 0);
    check("R10 out_c after reset", int'(out_c), 0);
    check("R10 done after reset", int'(calc_done), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule